// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This unit compares two floating-point operands and records the outcome in a single condition bit. The operands arrive as raw bit patterns and are read as single or double precision. A 4-bit condition code picks one of sixteen predicates. Each predicate is some mix of three relations: "unordered", "equal" and "less than". A request is a single-cycle strobe. The condition bit is updated on the next clock edge.

The upper half of the code space repeats the relations of the lower half. The two halves differ only in how they treat NaN operands. The lower (quiet) half reports invalid-operation only for quiet NaNs. The upper (signalling) half reports it for every NaN. When invalid-operation is reported and its trap is enabled, the condition bit keeps its previous value, so the trap handler sees the state from before the compare. An invalid-cause pulse reports every invalid compare, whether the trap is enabled or not.

Top module: `fp_cond_unit`

## Requirements
- R1: While reset (`rst_n` low) is applied, and on the first edge after it is released, `cond_flag` and `invalid_pulse` are both 0.
- R2: The low three bits of `cond_code` select the relation terms that are ORed together: bit 0 adds "unordered", bit 1 adds "equal" and bit 2 adds "less than". Code 0 always yields false. Bit 3 does not change the relation.
- R3: A NaN is any pattern whose exponent is all ones and whose fraction is nonzero. The pair is unordered when either operand is a NaN, and an unordered pair is neither equal nor less.
- R4: Ordered operands compare by numeric value. Plus zero and minus zero are equal. Minus infinity is below every finite value and plus infinity is above every finite value. Subnormals take part as ordinary values.
- R5: When `cond_code[3]` is 0, invalid-operation is raised only if an operand is a quiet NaN, meaning a NaN whose top fraction bit is 1.
- R6: When `cond_code[3]` is 1, invalid-operation is raised if either operand is any NaN.
- R7: When invalid-operation is raised while `trap_invalid_en` is 1, `cond_flag` keeps its previous value. The invalid pulse still fires.
- R8: `cond_flag` changes only on the edge that samples `op_valid` high, and holds otherwise. `invalid_pulse` is high for exactly the one cycle after a strobed compare that raised invalid-operation.
- R9: With `dbl_sel` 0, each operand is the single-precision value in bits 31:0, and bits 63:32 have no effect. With `dbl_sel` 1, all 64 bits form a double.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | One-cycle strobe starting a compare |
| dbl_sel | input | 1 | 1 = double precision, 0 = single precision in the low word |
| cond_code | input | 4 | Predicate select: bits 2:0 relation terms, bit 3 signalling |
| trap_invalid_en | input | 1 | Invalid-operation trap enable |
| opnd_a | input | 64 | First operand bit pattern |
| opnd_b | input | 64 | Second operand bit pattern |
| cond_flag | output | 1 | Registered condition bit |
| invalid_pulse | output | 1 | One-cycle invalid-operation cause |

## Verification
The assertions take for granted that all inputs are free of X and Z whenever `op_valid` is high. They also assume that reset is applied before the first strobe, so every `$past` and `$stable` reference starts from a known register value.

The stimulus keeps to these conditions. It holds reset for several cycles with every input driven to zero, and it changes inputs only on the falling clock edge. Idle cycles between strobes drive arbitrary operand patterns, which checks that these patterns leave the condition bit untouched.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
   // bit positions inside the condition code
   localparam int CB_UN  = 0;
   localparam int CB_EQ  = 1;
   localparam int CB_LT  = 2;
   localparam int CB_SIG = 3;
   localparam int CODE_W = 4;

   // relation summary of one operand pair
   typedef struct packed {
      logic un;   // either operand NaN
      logic qn;   // either operand quiet NaN
      logic eq;   // ordered and equal
      logic lt;   // ordered and a < b
   } fpc_rel_t;
endpackage

// File: rtl/fpc_classify.sv
module fpc_classify #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int FMT_W = 1 + EXP_W + FRAC_W
) (
   input  logic [FMT_W-1:0] bits_i,
   output logic             sign_o,
   output logic [FMT_W-2:0] mag_o,
   output logic             nan_o,
   output logic             qnan_o,
   output logic             zero_o
);
   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_top;

   assign exp_f   = bits_i[FMT_W-2:FRAC_W];
   assign frac_f  = bits_i[FRAC_W-1:0];
   assign exp_top = &exp_f;

   assign sign_o = bits_i[FMT_W-1];
   assign mag_o  = bits_i[FMT_W-2:0];
   assign nan_o  = exp_top & (|frac_f);
   assign qnan_o = exp_top & frac_f[FRAC_W-1];
   assign zero_o = ~(|bits_i[FMT_W-2:0]);
endmodule

// File: rtl/fpc_order.sv
module fpc_order #(
   parameter int MAG_W = 31
) (
   input  logic             sign_a_i,
   input  logic [MAG_W-1:0] mag_a_i,
   input  logic             zero_a_i,
   input  logic             sign_b_i,
   input  logic [MAG_W-1:0] mag_b_i,
   input  logic             zero_b_i,
   output logic             eq_o,
   output logic             lt_o
);
   logic both_zero;
   logic mag_lt;
   logic mag_gt;

   assign both_zero = zero_a_i & zero_b_i;
   assign mag_lt    = mag_a_i < mag_b_i;
   assign mag_gt    = mag_b_i < mag_a_i;
   assign eq_o      = both_zero | ((sign_a_i == sign_b_i) && (mag_a_i == mag_b_i));

   always_comb begin
      if (both_zero)                lt_o = 1'b0;
      else if (sign_a_i != sign_b_i) lt_o = sign_a_i;
      else if (sign_a_i)            lt_o = mag_gt;
      else                          lt_o = mag_lt;
   end
endmodule

// File: rtl/fpc_lane.sv
module fpc_lane
   import fpc_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int FMT_W = 1 + EXP_W + FRAC_W,
   localparam int MAG_W = FMT_W - 1
) (
   input  logic [FMT_W-1:0] a_i,
   input  logic [FMT_W-1:0] b_i,
   output fpc_rel_t         rel_o
);
   logic [FMT_W-1:0] opnd [2];
   logic             sgn  [2];
   logic [MAG_W-1:0] mag  [2];
   logic             nan  [2];
   logic             qnan [2];
   logic             zro  [2];
   logic             eq_raw;
   logic             lt_raw;

   assign opnd[0] = a_i;
   assign opnd[1] = b_i;

   for (genvar i = 0; i < 2; i++) begin : g_cls
      fpc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
         .bits_i (opnd[i]),
         .sign_o (sgn[i]),
         .mag_o  (mag[i]),
         .nan_o  (nan[i]),
         .qnan_o (qnan[i]),
         .zero_o (zro[i])
      );
   end

   fpc_order #(.MAG_W(MAG_W)) u_ord (
      .sign_a_i (sgn[0]),
      .mag_a_i  (mag[0]),
      .zero_a_i (zro[0]),
      .sign_b_i (sgn[1]),
      .mag_b_i  (mag[1]),
      .zero_b_i (zro[1]),
      .eq_o     (eq_raw),
      .lt_o     (lt_raw)
   );

   always_comb begin
      rel_o.un = nan[0] | nan[1];
      rel_o.qn = qnan[0] | qnan[1];
      rel_o.eq = eq_raw & ~rel_o.un;
      rel_o.lt = lt_raw & ~rel_o.un;
   end
endmodule

// File: rtl/fpc_decide.sv
module fpc_decide
   import fpc_pkg::*;
(
   input  fpc_rel_t          rel_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              pred_o,
   output logic              invalid_o
);
   assign pred_o = (code_i[CB_UN] & rel_i.un)
                 | (code_i[CB_EQ] & rel_i.eq)
                 | (code_i[CB_LT] & rel_i.lt);
   assign invalid_o = code_i[CB_SIG] ? rel_i.un : rel_i.qn;
endmodule

// File: rtl/fp_cond_unit.sv
module fp_cond_unit
   import fpc_pkg::*;
#(
   parameter int SGL_EXP     = 8,
   parameter int SGL_FRAC    = 23,
   parameter int DBL_EXP     = 11,
   parameter int DBL_FRAC    = 52,
   parameter bit SUPPORT_DBL = 1'b1,
   localparam int SGL_W      = 1 + SGL_EXP + SGL_FRAC,
   localparam int DBL_W      = 1 + DBL_EXP + DBL_FRAC,
   localparam int DATA_W     = (DBL_W > SGL_W) ? DBL_W : SGL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic              dbl_sel,
   input  logic [CODE_W-1:0] cond_code,
   input  logic              trap_invalid_en,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic              cond_flag,
   output logic              invalid_pulse
);
   // elaboration-time parameter checks
   if (SGL_EXP < 2 || SGL_FRAC < 2) begin : g_bad_sgl
      $error("fp_cond_unit: single format fields too narrow");
   end
   if (DBL_EXP < 2 || DBL_FRAC < 2) begin : g_bad_dbl
      $error("fp_cond_unit: double format fields too narrow");
   end
   if (DBL_W < SGL_W) begin : g_bad_order
      $error("fp_cond_unit: double format narrower than single");
   end

   fpc_rel_t rel_s;
   fpc_rel_t rel_d;
   fpc_rel_t rel_sel;
   logic     pred;
   logic     invalid_now;
   logic     block_wr;

   fpc_lane #(.EXP_W(SGL_EXP), .FRAC_W(SGL_FRAC)) u_lane_s (
      .a_i   (opnd_a[SGL_W-1:0]),
      .b_i   (opnd_b[SGL_W-1:0]),
      .rel_o (rel_s)
   );

   if (SUPPORT_DBL) begin : g_dbl
      fpc_lane #(.EXP_W(DBL_EXP), .FRAC_W(DBL_FRAC)) u_lane_d (
         .a_i   (opnd_a[DBL_W-1:0]),
         .b_i   (opnd_b[DBL_W-1:0]),
         .rel_o (rel_d)
      );
      assign rel_sel = dbl_sel ? rel_d : rel_s;
   end else begin : g_sgl_only
      assign rel_d   = rel_s;
      assign rel_sel = rel_s;
   end

   fpc_decide u_dec (
      .rel_i     (rel_sel),
      .code_i    (cond_code),
      .pred_o    (pred),
      .invalid_o (invalid_now)
   );

   assign block_wr = invalid_now & trap_invalid_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond_flag     <= 1'b0;
         invalid_pulse <= 1'b0;
      end else begin
         invalid_pulse <= op_valid & invalid_now;
         if (op_valid && !block_wr) cond_flag <= pred;
      end
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(cond_flag)) else $error("idle changed flag"); // R8
   AST_TRAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && trap_invalid_en && invalid_now) |=> $stable(cond_flag)) else $error("trap overwrote flag"); // R7
   AST_PULSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      invalid_pulse |-> $past(op_valid)) else $error("pulse without request"); // R8
   AST_FALSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && cond_code[2:0] == 3'd0 && !block_wr) |=> !cond_flag) else $error("false predicate set flag"); // R2
   AST_QUIET_SNAN: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !cond_code[CB_SIG] && !rel_sel.qn) |=> !invalid_pulse) else $error("quiet code raised invalid"); // R5
   AST_SIG_NAN: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && cond_code[CB_SIG] && rel_sel.un) |=> invalid_pulse) else $error("signalling NaN missed"); // R6
endmodule

// File: tb/tb_fp_cond_unit.sv
`timescale 1ns/1ps
module tb_fp_cond_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic        dbl_sel = 1'b0;
   logic [3:0]  cond_code = 4'd0;
   logic        trap_invalid_en = 1'b0;
   logic [63:0] opnd_a = 64'd0;
   logic [63:0] opnd_b = 64'd0;
   logic        cond_flag;
   logic        invalid_pulse;

   int checks = 0;
   int failures = 0;
   bit exp_flag = 1'b0;
   bit exp_pulse = 1'b0;

   always #10 clk = ~clk;

   fp_cond_unit dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .dbl_sel(dbl_sel),
      .cond_code(cond_code), .trap_invalid_en(trap_invalid_en),
      .opnd_a(opnd_a), .opnd_b(opnd_b),
      .cond_flag(cond_flag), .invalid_pulse(invalid_pulse)
   );

   // ---------------- reference model ----------------
   function automatic bit m_nan(input logic [63:0] x, input bit dbl);
      if (dbl) return (x[62:52] == 11'h7FF) && (x[51:0] != 52'd0);
      return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
   endfunction

   function automatic bit m_qnan(input logic [63:0] x, input bit dbl);
      if (dbl) return x[62:51] == 12'hFFF;
      return x[30:22] == 9'h1FF;
   endfunction

   // monotone integer key: larger key means larger value
   function automatic logic [63:0] m_key(input logic [63:0] x, input bit dbl);
      logic [63:0] v;
      logic [63:0] top;
      v   = dbl ? x : {32'd0, x[31:0]};
      top = dbl ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
      if ((v & ~top) == 64'd0) return top;
      if ((v & top) != 64'd0) return (dbl ? ~v : {32'd0, ~v[31:0]});
      return v | top;
   endfunction

   task automatic check(input string tag, input string what, input bit act, input bit exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
      end
   endtask

   // one clock: drive at falling edge, predict, compare after rising edge
   task automatic step(input bit v, input bit dbl, input logic [3:0] code, input bit trap,
                       input logic [63:0] a, input logic [63:0] b, input string tag);
      bit un, eq, lt, inv, pred;
      @(negedge clk);
      op_valid = v; dbl_sel = dbl; cond_code = code; trap_invalid_en = trap;
      opnd_a = a; opnd_b = b;
      un   = m_nan(a, dbl) || m_nan(b, dbl);
      eq   = !un && (m_key(a, dbl) == m_key(b, dbl));
      lt   = !un && (m_key(a, dbl) <  m_key(b, dbl));
      pred = (code[0] && un) || (code[1] && eq) || (code[2] && lt);
      inv  = code[3] ? un : (m_qnan(a, dbl) || m_qnan(b, dbl));
      exp_pulse = v && inv;
      if (v && !(inv && trap)) exp_flag = pred;
      @(posedge clk);
      #1;
      check(tag, "cond_flag", cond_flag, exp_flag);
      check(code[3] ? "R6" : "R5", "invalid_pulse", invalid_pulse, exp_pulse);
   endtask

   function automatic logic [63:0] pick(input int i, input bit dbl);
      if (dbl) begin
         case (i)
            0: return 64'h0000_0000_0000_0000;
            1: return 64'h8000_0000_0000_0000;
            2: return 64'h3FF0_0000_0000_0000;
            3: return 64'hBFF0_0000_0000_0000;
            4: return 64'h4000_0000_0000_0000;
            5: return 64'h7FF0_0000_0000_0000;
            6: return 64'hFFF0_0000_0000_0000;
            7: return 64'h7FF8_0000_0000_0000;
            8: return 64'h7FF4_0000_0000_0000;
            9: return 64'h0000_0000_0000_0001;
            default: return 64'h7FEF_FFFF_FFFF_FFFF;
         endcase
      end
      case (i)
         0: return 64'h0;
         1: return 64'h8000_0000;
         2: return 64'h3F80_0000;
         3: return 64'hBF80_0000;
         4: return 64'h4000_0000;
         5: return 64'h7F80_0000;
         6: return 64'hFF80_0000;
         7: return 64'h7FC0_0000;
         8: return 64'h7FA0_0000;
         9: return 64'h0000_0001;
         default: return 64'h7F7F_FFFF;
      endcase
   endfunction

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check("R1", "cond_flag in reset", cond_flag, 1'b0);
      check("R1", "invalid_pulse in reset", invalid_pulse, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1", "cond_flag after release", cond_flag, 1'b0);
      check("R1", "invalid_pulse after release", invalid_pulse, 1'b0);

      // R2: relation terms, bit 3 does not alter relation
      step(1, 0, 4'd4, 0, 64'h3F80_0000, 64'h4000_0000, "R2");
      step(1, 0, 4'd0, 0, 64'h3F80_0000, 64'h3F80_0000, "R2");
      step(1, 0, 4'd12, 0, 64'h3F80_0000, 64'h4000_0000, "R2");
      step(1, 0, 4'd2, 0, 64'h4000_0000, 64'h3F80_0000, "R2");
      step(1, 0, 4'd6, 0, 64'h4000_0000, 64'h4000_0000, "R2");
      // R3: unordered
      step(1, 0, 4'd1, 0, 64'h7FC0_0000, 64'h3F80_0000, "R3");
      step(1, 0, 4'd6, 0, 64'h7FA0_0000, 64'h7FA0_0000, "R3");
      // R4: zeros, infinities, subnormal
      step(1, 1, 4'd2, 0, 64'h8000_0000_0000_0000, 64'h0, "R4");
      step(1, 1, 4'd4, 0, 64'hFFF0_0000_0000_0000, 64'hFFEF_FFFF_FFFF_FFFF, "R4");
      step(1, 0, 4'd4, 0, 64'h0, 64'h0000_0001, "R4");
      step(1, 0, 4'd4, 0, 64'h8000_0000, 64'h0, "R4");
      // R5/R6: quiet vs signalling invalid
      step(1, 0, 4'd2, 0, 64'h7FA0_0000, 64'h0, "R5");
      step(1, 0, 4'd10, 0, 64'h7FA0_0000, 64'h0, "R6");
      // R7: trap keeps flag
      step(1, 0, 4'd6, 0, 64'h0, 64'h0, "R7");
      step(1, 0, 4'd9, 1, 64'h7FA0_0000, 64'h0, "R7");
      step(1, 0, 4'd1, 1, 64'h7FC0_0000, 64'h0, "R7");
      // R8: idle cycles hold and pulse clears
      step(0, 0, 4'd0, 0, 64'h7FC0_0000, 64'h0, "R8");
      step(0, 1, 4'd4, 0, 64'h0, 64'h3FF0_0000_0000_0000, "R8");
      // R9: upper bits ignored in single mode
      step(1, 0, 4'd2, 0, 64'hDEAD_BEEF_3F80_0000, 64'h0123_4567_3F80_0000, "R9");
      step(1, 0, 4'd9, 0, 64'h7FF8_0000_0000_0000, 64'h0, "R9");

      // sweep all codes and operand pairs in both precisions
      for (int d = 0; d < 2; d++) begin
         for (int c = 0; c < 16; c++) begin
            for (int i = 0; i < 11; i++) begin
               for (int j = 0; j < 11; j++) begin
                  logic [63:0] junk;
                  junk = {$urandom, $urandom};
                  step(1, d[0], c[3:0], ($urandom % 3) == 0,
                       pick(i, d[0]) | (d[0] ? 64'd0 : {junk[63:32], 32'd0}),
                       pick(j, d[0]), d[0] ? "R4" : "R9");
                  if ((($urandom) & 7) == 0)
                     step(0, d[0], 4'($urandom), 1'($urandom), junk, ~junk, "R8");
               end
            end
         end
      end
      finish_run();
   end
endmodule